// File: doc/BRIEF.md
# Split-Capacity Dual-Clock Word Queue

This block carries data words from a producer running on one clock to a consumer running on an unrelated clock. The storage can run as one queue of 16 entries, or it can be divided at run time into two separate queues of 8 entries each. The input `split` chooses between the two arrangements. In the divided arrangement a two-bit control code picks the queue that takes writes, gives reads and drives the flags. The same code also clears one queue at a time.

Writes and reads use active-low strobes, each on the rising edge of its own clock. The block reports three active-low flags for the queue that is currently picked:
- full, computed on the write side;
- empty, computed on the read side;
- half-full, computed on the read side, with a threshold that follows the capacity in use.

Pointers cross between the clock domains in Gray code through two-flop synchronizers. Both flags therefore run a little late, and always on the safe side. `split` may only change while both queues are being cleared. The word width is a parameter: 64 for the memory-to-system direction, 72 for the direction that carries check bits.

Top module: `qsplit_fifo`

## Requirements
- R1: While `arst_n` is low, all three flags read idle: `empty_l`=0, `full_l`=1, `half_l`=1, and `rdata`=0. The same idle flags are shown while a queue-clear code is applied to the queue on view.
- R2: The code `rs` works as follows:
  - 2'b00 clears queue A (the single 16-entry queue when `split`=0).
  - 2'b01 clears queue B.
  - 2'b10 picks queue A and 2'b11 picks queue B for writes, reads and flags.
  - With `split`=0, every access and every flag uses queue A, whatever `rs[0]` is.
- R3: A rising `wclk` edge with `wr_n`=0 stores `wdata` in the picked queue when that queue is not full. `empty_l` then goes high within a few `rclk` cycles.
- R4: A rising `rclk` edge with `rd_n`=0 on a non-empty queue loads the oldest stored word into `rdata`. Words leave in the order they arrived, including across pointer wrap.
- R5: `full_l` is low while the picked queue holds its capacity: 16 words with `split`=0, or 8 words with `split`=1.
- R6: `half_l` is low while the picked queue holds at least half its capacity (8 or 4 words), and high below that. It is never low while `empty_l` is low.
- R7: A write to a full queue is dropped. The stored words and their order are unchanged.
- R8: A read from an empty queue is dropped. `rdata` keeps its value and the read pointer does not move.
- R9: With `split`=1, writing, reading or clearing one queue leaves the words held in the other queue untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_n | input | 1 | Asynchronous reset for both domains, active low |
| split | input | 1 | 0: one 16-entry queue; 1: two 8-entry queues |
| rs | input | 2 | Clear/pick code (see R2) |
| wclk | input | 1 | Write-side clock |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | DATA_W | Word to store |
| full_l | output | 1 | Picked queue full, active low |
| rclk | input | 1 | Read-side clock |
| rd_n | input | 1 | Read strobe, active low |
| rdata | output | DATA_W | Last word read |
| empty_l | output | 1 | Picked queue empty, active low |
| half_l | output | 1 | Picked queue at least half full, active low |

## Verification
The hardest situation to reach from the ports is a clear of one half while the other half still holds data. The stimulus reaches it in split mode: it loads queue A, loads queue B, clears B with code 01, checks that B reads empty, and then drains A and compares every word.

Pointer wrap needs the same queue to be filled and drained in rounds, so that both Gray pointers pass their top value. Overflow and underflow are provoked by strobing past the capacity and past empty. In both cases the later data reads and the `rdata` hold must show that nothing moved.

// File: rtl/qsplit_pkg.sv
package qsplit_pkg;
    localparam int GW = 16;

    function automatic logic [GW-1:0] to_gray(input logic [GW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GW-1:0] from_gray(input logic [GW-1:0] g);
        logic [GW-1:0] b;
        b[GW-1] = g[GW-1];
        for (int i = GW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/qsplit_sync.sv
module qsplit_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.s1 = d;
            st_d.s2 = st_q.s1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/qsplit_wptr.sv
module qsplit_wptr
    import qsplit_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 5
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          clr,
    input  logic          act,
    input  logic          req_n,
    input  logic          split,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-2:0] addr,
    output logic [PW-1:0] gray,
    output logic          full,
    output logic          go
);
    localparam logic [PW-1:0] CAP_ONE = PW'(DEPTH);
    localparam logic [PW-1:0] CAP_TWO = PW'(DEPTH / 2);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [PW-1:0] rbin_s, used, cap;

    assign rbin_s = PW'(from_gray(GW'(rgray_s)));
    assign used   = st_q.bin - rbin_s;
    assign cap    = split ? CAP_TWO : CAP_ONE;
    assign full   = (used >= cap);
    assign go     = act && !req_n && !full && !clr;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (go) begin
            st_d.bin  = st_q.bin + PW'(1);
            st_d.gray = PW'(to_gray(GW'(st_d.bin)));
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign addr = st_q.bin[PW-2:0];
    assign gray = st_q.gray;
endmodule

// File: rtl/qsplit_rptr.sv
module qsplit_rptr
    import qsplit_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 5
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          clr,
    input  logic          act,
    input  logic          req_n,
    input  logic          split,
    input  logic [PW-1:0] wgray_s,
    output logic [PW-2:0] addr,
    output logic [PW-1:0] gray,
    output logic          empty,
    output logic          half,
    output logic          go
);
    localparam logic [PW-1:0] CAP_ONE = PW'(DEPTH);
    localparam logic [PW-1:0] CAP_TWO = PW'(DEPTH / 2);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [PW-1:0] wbin_s, used, cap;

    assign wbin_s = PW'(from_gray(GW'(wgray_s)));
    assign used   = wbin_s - st_q.bin;
    assign cap    = split ? CAP_TWO : CAP_ONE;
    assign empty  = (used == '0);
    assign half   = (used >= (cap >> 1));
    assign go     = act && !req_n && !empty && !clr;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (go) begin
            st_d.bin  = st_q.bin + PW'(1);
            st_d.gray = PW'(to_gray(GW'(st_d.bin)));
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign addr = st_q.bin[PW-2:0];
    assign gray = st_q.gray;
endmodule

// File: rtl/qsplit_fifo.sv
module qsplit_fifo #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 16
) (
    input  logic              arst_n,
    input  logic              split,
    input  logic [1:0]        rs,
    input  logic              wclk,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic              full_l,
    input  logic              rclk,
    input  logic              rd_n,
    output logic [DATA_W-1:0] rdata,
    output logic              empty_l,
    output logic              half_l
);
    localparam int AW     = $clog2(DEPTH);
    localparam int PW     = AW + 1;
    localparam int SUB_AW = AW - 1;
    localparam int NQ     = 2;

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_st_t;

    logic [NQ-1:0] clr, act, wgo, rgo, fullv, emptyv, halfv;
    logic [PW-1:0] wgray   [NQ];
    logic [PW-1:0] rgray   [NQ];
    logic [PW-1:0] wgray_s [NQ];
    logic [PW-1:0] rgray_s [NQ];
    logic [AW-1:0] wptr_a  [NQ];
    logic [AW-1:0] rptr_a  [NQ];
    logic [AW-1:0] waddr   [NQ];
    logic [AW-1:0] raddr   [NQ];
    logic          sel;

    logic [DATA_W-1:0] mem [DEPTH];
    rd_st_t rd_d, rd_q;

    // queue on view: B only in split mode with rs[0] set
    assign sel = split ? rs[0] : 1'b0;

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        assign clr[q] = !rs[1] && (rs[0] == 1'(q));
        assign act[q] = split ? (rs[0] == 1'(q)) : (q == 0);

        qsplit_wptr #(.DEPTH(DEPTH), .PW(PW)) u_wptr (
            .clk(wclk), .arst_n(arst_n), .clr(clr[q]), .act(act[q]),
            .req_n(wr_n), .split(split), .rgray_s(rgray_s[q]),
            .addr(wptr_a[q]), .gray(wgray[q]), .full(fullv[q]), .go(wgo[q])
        );

        qsplit_rptr #(.DEPTH(DEPTH), .PW(PW)) u_rptr (
            .clk(rclk), .arst_n(arst_n), .clr(clr[q]), .act(act[q]),
            .req_n(rd_n), .split(split), .wgray_s(wgray_s[q]),
            .addr(rptr_a[q]), .gray(rgray[q]), .empty(emptyv[q]),
            .half(halfv[q]), .go(rgo[q])
        );

        qsplit_sync #(.W(PW)) u_w2r (
            .clk(rclk), .arst_n(arst_n), .clr(clr[q]),
            .d(wgray[q]), .q(wgray_s[q])
        );

        qsplit_sync #(.W(PW)) u_r2w (
            .clk(wclk), .arst_n(arst_n), .clr(clr[q]),
            .d(rgray[q]), .q(rgray_s[q])
        );

        // in split mode each queue owns one half of the array
        assign waddr[q] = split ? {1'(q), wptr_a[q][SUB_AW-1:0]} : wptr_a[q];
        assign raddr[q] = split ? {1'(q), rptr_a[q][SUB_AW-1:0]} : rptr_a[q];
    end

    always_ff @(posedge wclk) begin
        if (wgo[sel]) mem[waddr[sel]] <= wdata;
    end

    always_comb begin
        rd_d = rd_q;
        if (rgo[sel]) rd_d.data = mem[raddr[sel]];
    end

    always_ff @(posedge rclk or negedge arst_n) begin
        if (!arst_n) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    assign rdata   = rd_q.data;
    assign full_l  = !fullv[sel];
    assign empty_l = !emptyv[sel];
    assign half_l  = !halfv[sel];
endmodule

// File: rtl/qsplit_fifo_chk.sv
module qsplit_fifo_chk #(
    parameter int DATA_W = 64
) (
    input logic              arst_n,
    input logic              split,
    input logic [1:0]        rs,
    input logic              wclk,
    input logic              rclk,
    input logic              rd_n,
    input logic              full_l,
    input logic              empty_l,
    input logic              half_l,
    input logic [DATA_W-1:0] rdata
);
    AST_CLEAR_SHOWS_EMPTY: assert property (@(posedge rclk) disable iff (!arst_n)
        (!rs[1] && (split || !rs[0])) |=> !empty_l); // R1

    AST_CLEAR_SHOWS_NOT_FULL: assert property (@(posedge wclk) disable iff (!arst_n)
        (!rs[1] && (split || !rs[0])) |=> full_l); // R2

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!arst_n)
        (!empty_l && !rd_n) |=> $stable(rdata)); // R8

    AST_EMPTY_NOT_HALF: assert property (@(posedge rclk) disable iff (!arst_n)
        !empty_l |-> half_l); // R6
endmodule

bind qsplit_fifo qsplit_fifo_chk #(.DATA_W(DATA_W)) u_chk (
    .arst_n(arst_n), .split(split), .rs(rs), .wclk(wclk), .rclk(rclk),
    .rd_n(rd_n), .full_l(full_l), .empty_l(empty_l), .half_l(half_l),
    .rdata(rdata)
);

// File: tb/qsplit_fifo_bench.sv
module qsplit_fifo_bench;
    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = CLK_PERIOD + 4;
    localparam int DW          = 64;
    localparam int DEPTH       = 16;
    localparam int NV          = 12;

    typedef struct packed {
        logic       spl;
        logic       q;
        logic [7:0] nw;
        logic [7:0] nr;
        logic       e;
        logic       h;
        logic       f;
    } vec_t;

    // split, queue, writes, reads, expected empty_l, half_l, full_l
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'd0,  8'd0,  1'b0, 1'b1, 1'b1},
        '{1'b0, 1'b0, 8'd7,  8'd0,  1'b1, 1'b1, 1'b1},
        '{1'b0, 1'b0, 8'd8,  8'd0,  1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b0, 8'd16, 8'd0,  1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b0, 8'd20, 8'd16, 1'b0, 1'b1, 1'b1},
        '{1'b0, 1'b0, 8'd10, 8'd3,  1'b1, 1'b1, 1'b1},
        '{1'b1, 1'b0, 8'd3,  8'd0,  1'b1, 1'b1, 1'b1},
        '{1'b1, 1'b0, 8'd4,  8'd0,  1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b0, 8'd8,  8'd0,  1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 8'd12, 8'd8,  1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b1, 8'd8,  8'd4,  1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b0, 8'd15, 8'd1,  1'b1, 1'b0, 1'b1}
    };

    logic          arst_n = 1'b0;
    logic          split  = 1'b0;
    logic [1:0]    rs     = 2'b10;
    logic          wclk   = 1'b0;
    logic          rclk   = 1'b0;
    logic          wr_n   = 1'b1;
    logic          rd_n   = 1'b1;
    logic [DW-1:0] wdata  = '0;
    logic [DW-1:0] rdata;
    logic          full_l, empty_l, half_l;

    always #(CLK_PERIOD / 2)  wclk = ~wclk;
    always #(RCLK_PERIOD / 2) rclk = ~rclk;

    qsplit_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_qsplit_fifo (
        .arst_n(arst_n), .split(split), .rs(rs),
        .wclk(wclk), .wr_n(wr_n), .wdata(wdata), .full_l(full_l),
        .rclk(rclk), .rd_n(rd_n), .rdata(rdata),
        .empty_l(empty_l), .half_l(half_l)
    );

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [DW-1:0] mdl [2][DEPTH];
    int m_cnt [2];
    int m_head[2];
    int m_tail[2];

    function automatic int cap_now();
        return split ? DEPTH / 2 : DEPTH;
    endfunction

    function automatic logic [DW-1:0] pat(int a, int b);
        return {32'(a) ^ 32'hC0DE_0000, 32'(b) * 32'h0101_0101 + 32'(a)};
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mclear(int q);
        m_cnt[q] = 0; m_head[q] = 0; m_tail[q] = 0;
    endtask

    task automatic settle();
        repeat (5) @(negedge rclk);
        repeat (2) @(negedge wclk);
    endtask

    task automatic put(int q, logic [DW-1:0] d);
        @(negedge wclk);
        wr_n  = 1'b0;
        wdata = d;
        @(negedge wclk);
        wr_n = 1'b1;
        if (m_cnt[q] < cap_now()) begin
            mdl[q][m_tail[q]] = d;
            m_tail[q] = (m_tail[q] + 1) % DEPTH;
            m_cnt[q]++;
        end
    endtask

    task automatic get(int q, string tag);
        logic [DW-1:0] prev;
        prev = rdata;
        @(negedge rclk);
        rd_n = 1'b0;
        @(negedge rclk);
        rd_n = 1'b1;
        if (m_cnt[q] > 0) begin
            check(tag, rdata, mdl[q][m_head[q]]);
            m_head[q] = (m_head[q] + 1) % DEPTH;
            m_cnt[q]--;
        end else begin
            check(tag, rdata, prev);
        end
    endtask

    task automatic qreset(int q);
        @(negedge wclk);
        rs = {1'b0, 1'(q)};
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
        rs = 2'b10;
        mclear(q);
    endtask

    task automatic pick(int q);
        @(negedge wclk);
        rs = {1'b1, 1'(q)};
        settle();
    endtask

    task automatic flags(string tag, logic e, logic h, logic f);
        check({tag, " R3 empty_l"}, DW'(empty_l), DW'(e));
        check({tag, " R6 half_l"},  DW'(half_l),  DW'(h));
        check({tag, " R5 full_l"},  DW'(full_l),  DW'(f));
    endtask

    initial begin
        repeat (200000) @(posedge wclk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog R1-wide run actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        mclear(0);
        mclear(1);
        repeat (3) @(negedge wclk);
        // R1: flags and data while reset is asserted
        check("R1 empty_l at reset", DW'(empty_l), DW'(1'b0));
        check("R1 full_l at reset",  DW'(full_l),  DW'(1'b1));
        check("R1 half_l at reset",  DW'(half_l),  DW'(1'b1));
        check("R1 rdata at reset",   rdata,        '0);
        @(negedge wclk);
        arst_n = 1'b1;
        settle();

        // table walk: fill levels, overflow, drain, both queue shapes
        for (int v = 0; v < NV; v++) begin
            @(negedge wclk);
            split = VECS[v].spl;
            qreset(0);
            qreset(1);
            pick(int'(VECS[v].q));
            for (int k = 0; k < int'(VECS[v].nw); k++) put(int'(VECS[v].q), pat(v, k));
            settle();
            for (int k = 0; k < int'(VECS[v].nr); k++) get(int'(VECS[v].q), "R4/R7 table data");
            settle();
            flags("table", VECS[v].e, VECS[v].h, VECS[v].f);
        end

        // R9 and R2: two queues side by side, then clear only queue B
        @(negedge wclk);
        split = 1'b1;
        qreset(0);
        qreset(1);
        pick(0);
        for (int k = 0; k < 5; k++) put(0, pat(100, k));
        pick(1);
        for (int k = 0; k < 2; k++) put(1, pat(101, k));
        settle();
        check("R9 queue B half_l", DW'(half_l), DW'(1'b1));
        for (int k = 0; k < 2; k++) get(1, "R9 queue B data");
        pick(0);
        check("R9 queue A half_l", DW'(half_l), DW'(1'b0));
        pick(1);
        for (int k = 0; k < 3; k++) put(1, pat(102, k));
        qreset(1);
        pick(1);
        check("R2 cleared B empty_l", DW'(empty_l), DW'(1'b0));
        pick(0);
        check("R2 A kept after B clear", DW'(empty_l), DW'(1'b1));
        for (int k = 0; k < 5; k++) get(0, "R9 queue A data after B clear");
        settle();
        check("R9 queue A drained", DW'(empty_l), DW'(1'b0));

        // R2: single-queue mode ignores rs[0]
        @(negedge wclk);
        split = 1'b0;
        qreset(0);
        qreset(1);
        pick(1);
        for (int k = 0; k < 3; k++) put(0, pat(200, k));
        pick(0);
        check("R2 rs0 ignored empty_l", DW'(empty_l), DW'(1'b1));
        for (int k = 0; k < 3; k++) get(0, "R2 rs0 ignored data");

        // R8: reads on an empty queue move nothing
        settle();
        get(0, "R8 read on empty holds rdata");
        get(0, "R8 second read on empty");
        put(0, pat(300, 0));
        settle();
        get(0, "R8 pointer unmoved data");

        // R4: wrap both pointers several times
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 12; k++) put(0, pat(400 + r, k));
            settle();
            for (int k = 0; k < 12; k++) get(0, "R4 wrap order");
        end
        settle();
        flags("wrap end", 1'b0, 1'b1, 1'b1);

        // R1: asynchronous reset with data held
        for (int k = 0; k < 3; k++) put(0, pat(500, k));
        settle();
        @(negedge wclk);
        arst_n = 1'b0;
        #1;
        check("R1 empty_l after mid-run reset", DW'(empty_l), DW'(1'b0));
        check("R1 half_l after mid-run reset",  DW'(half_l),  DW'(1'b1));
        check("R1 full_l after mid-run reset",  DW'(full_l),  DW'(1'b1));
        check("R1 rdata after mid-run reset",   rdata,        '0);
        @(negedge wclk);
        arst_n = 1'b1;
        mclear(0);
        mclear(1);
        settle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule